// File: doc/BRIEF.md
# Byte-Synchronous Receive Error and Hunt Controller

This block sits behind the receive deserializer of a byte-synchronous link. Once an external sync detector reports a match, the block accepts characters, each with its parity flag, its CRC-mismatch result and a control-character match, and passes them through a four-entry FIFO to a buffer write port. The buffer write port has a ready signal. The block ends a message either when a control character closes the block or when an error occurs. It reports the end of a message with a one-cycle close strobe and a four-bit status. It then goes back to hunting for sync, and while hunting it throws incoming characters away.

Errors are ranked. Carrier loss outranks every other condition. It drops whatever is still queued and closes at once, with only its own bit set. A FIFO overrun replaces the newest queued byte with the arriving one. A parity error keeps the offending byte. Both of these wait until the FIFO has drained before the close is issued. The CRC status bit is lagged by one character, so the value reported at close time belongs to the character before the last one received. A saturating counter tracks parity errors.

Top module: `bsc_rx_ctrl`

## Requirements
- R1: After reset: `hunting`=1, `close_valid`=0, `irq`=0, `buf_wvalid`=0 and `perr_count`=0.
- R2: While `hunting`=1, characters are dropped and nothing is written. On the clock after `sync_found`, the block receives, and each accepted character then appears on `buf_wdata` with `buf_wvalid`=1, in arrival order, and is removed when `buf_ready`=1.
- R3: The FIFO holds 4 characters. A character that arrives while 4 are queued replaces the newest one. The message then closes with status bit 3 (overrun) set, and no further characters are accepted.
- R4: Apart from a carrier-loss close, `close_valid` pulses for exactly one cycle, and only after every queued character has been written. `hunting` is 1 in that cycle.
- R5: If `carrier_ok` drops while a message is in progress, the close pulse follows in the very next cycle with status `4'b0100` (bit 2 only). Queued characters are discarded, and any pending parity or overrun condition is not reported.
- R6: A character flagged by `rx_par_err` is still written. The message then closes with status bit 1 (parity) set, and later characters are ignored.
- R7: Every accepted character with `rx_par_err`=1 increments `perr_count`. The counter stops at its maximum value (15 by default) and does not wrap.
- R8: Status bit 0 (CRC) at close time equals the `rx_crc_err` that came with the character before the last accepted one. It reads 0 when the message has only one character.
- R9: A character with `rx_ctl_end`=1 is written and ends the message. The close then carries bit 0 as defined in R8 and bits 3..1 equal to 0.
- R10: `irq` equals `irq_en` during the cycle of each close pulse, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | Character strobe |
| rx_par_err | input | 1 | Parity error on this character |
| rx_crc_err | input | 1 | CRC unit mismatch result through this character |
| rx_ctl_end | input | 1 | Character matches the block-ending control code |
| sync_found | input | 1 | Sync detector match, leaves hunt |
| carrier_ok | input | 1 | Carrier detect, 1 = present |
| irq_en | input | 1 | Receive interrupt enable |
| buf_ready | input | 1 | Buffer write port can take a byte |
| buf_wdata | output | 8 | Byte to the buffer |
| buf_wvalid | output | 1 | `buf_wdata` is valid |
| close_valid | output | 1 | One-cycle buffer close strobe |
| close_stat | output | 4 | Close status {overrun, carrier, parity, crc} |
| irq | output | 1 | Receive interrupt pulse |
| perr_count | output | 4 | Saturating parity error count |
| hunting | output | 1 | Receiver is searching for sync |

## Verification
The hardest case to reach is carrier loss while another error is already waiting on a full or partly full FIFO. That is the only case that shows carrier loss overriding the other errors and dropping queued data. The bench holds `buf_ready` low so the queue cannot drain. It then raises a parity error to make the close wait, and drops the carrier before releasing the buffer port. It checks the close strobe in the very next cycle and confirms that no queued byte comes out afterwards. Overrun uses the same stalled buffer port, so that a fifth character lands on a full queue.

// File: rtl/bsc_rx_pkg.sv
package bsc_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2
  } rx_state_e;

  localparam int STAT_W  = 4;
  localparam int STAT_OV = 3;
  localparam int STAT_CD = 2;
  localparam int STAT_PR = 1;
  localparam int STAT_CR = 0;
endpackage

// File: rtl/bsc_rx_fifo.sv
module bsc_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d, last_idx, wr_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_ins, do_ovw, do_pop, mem_we;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign count    = cnt_q;
  assign rdata    = mem_q[rd_q];
  assign last_idx = (wr_q == '0) ? AW'(DEPTH - 1) : wr_q - 1'b1;

  always_comb begin
    do_ins = push && !full && !flush;
    do_ovw = push && full && !flush;
    do_pop = pop && !empty && !flush;
    mem_we = do_ins || do_ovw;
    wr_idx = do_ovw ? last_idx : wr_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_ins) wr_d = nxt(wr_q);
      if (do_pop) rd_d = nxt(rd_q);
      cnt_d = cnt_q + CW'(do_ins) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[wr_idx] <= wdata;
  end
endmodule

// File: rtl/bsc_rx_perr_cnt.sv
module bsc_rx_perr_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_max;

  assign at_max = (cnt_q == {W{1'b1}});
  assign count  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !at_max) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bsc_rx_crc_track.sv
module bsc_rx_crc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  input  logic crc_in,
  output logic cr_stat
);
  logic hold_q, hold_d, cr_q, cr_d;

  assign cr_stat = cr_q;

  always_comb begin
    hold_d = hold_q;
    cr_d   = cr_q;
    if (restart) begin
      hold_d = 1'b0;
      cr_d   = 1'b0;
    end else if (step) begin
      cr_d   = hold_q;
      hold_d = crc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cr_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      cr_q   <= cr_d;
    end
  end
endmodule

// File: rtl/bsc_rx_ctrl.sv
module bsc_rx_ctrl
  import bsc_rx_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int PERR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     rx_byte,
  input  logic              rx_valid,
  input  logic              rx_par_err,
  input  logic              rx_crc_err,
  input  logic              rx_ctl_end,
  input  logic              sync_found,
  input  logic              carrier_ok,
  input  logic              irq_en,
  input  logic              buf_ready,
  output logic [DW-1:0]     buf_wdata,
  output logic              buf_wvalid,
  output logic              close_valid,
  output logic [STAT_W-1:0] close_stat,
  output logic              irq,
  output logic [PERR_W-1:0] perr_count,
  output logic              hunting
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  rx_state_e         st_q, st_d;
  logic              pend_ov_q, pend_ov_d, pend_pr_q, pend_pr_d;
  logic              close_q, close_d, irq_q, irq_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              accept, lost, flush, f_empty, f_full, cr_stat, restart;
  logic [CW-1:0]     fifo_cnt;

  assign lost       = !carrier_ok && (st_q != ST_HUNT);
  assign accept     = (st_q == ST_RECV) && rx_valid && carrier_ok;
  assign restart    = (st_q == ST_HUNT) && sync_found;
  assign flush      = lost;
  assign buf_wvalid = !f_empty;
  assign hunting    = (st_q == ST_HUNT);
  assign close_valid = close_q;
  assign close_stat = stat_q;
  assign irq        = irq_q;

  bsc_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(accept), .wdata(rx_byte),
    .pop(buf_ready), .rdata(buf_wdata), .empty(f_empty), .full(f_full),
    .count(fifo_cnt)
  );

  bsc_rx_perr_cnt #(.W(PERR_W)) u_perr (
    .clk(clk), .rst_n(rst_n), .inc(accept && rx_par_err), .count(perr_count)
  );

  bsc_rx_crc_track u_crc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(accept),
    .crc_in(rx_crc_err), .cr_stat(cr_stat)
  );

  always_comb begin
    st_d      = st_q;
    pend_ov_d = pend_ov_q;
    pend_pr_d = pend_pr_q;
    close_d   = 1'b0;
    stat_d    = stat_q;
    unique case (st_q)
      ST_HUNT: begin
        if (sync_found) begin
          st_d      = ST_RECV;
          pend_ov_d = 1'b0;
          pend_pr_d = 1'b0;
        end
      end
      ST_RECV: begin
        if (lost) begin
          st_d   = ST_HUNT;
          close_d = 1'b1;
          stat_d = STAT_W'(1) << STAT_CD;
        end else if (accept && (f_full || rx_par_err || rx_ctl_end)) begin
          st_d      = ST_DRAIN;
          pend_ov_d = f_full;
          pend_pr_d = rx_par_err;
        end
      end
      ST_DRAIN: begin
        if (lost) begin
          st_d   = ST_HUNT;
          close_d = 1'b1;
          stat_d = STAT_W'(1) << STAT_CD;
        end else if (f_empty) begin
          st_d    = ST_HUNT;
          close_d = 1'b1;
          stat_d  = '0;
          stat_d[STAT_OV] = pend_ov_q;
          stat_d[STAT_PR] = pend_pr_q;
          stat_d[STAT_CR] = cr_stat;
        end
      end
      default: st_d = ST_HUNT;
    endcase
    irq_d = close_d && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      pend_ov_q <= 1'b0;
      pend_pr_q <= 1'b0;
      close_q   <= 1'b0;
      irq_q     <= 1'b0;
      stat_q    <= '0;
    end else begin
      st_q      <= st_d;
      pend_ov_q <= pend_ov_d;
      pend_pr_q <= pend_pr_d;
      close_q   <= close_d;
      irq_q     <= irq_d;
      stat_q    <= stat_d;
    end
  end
endmodule

// File: rtl/bsc_rx_chk.sv
module bsc_rx_chk #(
  parameter int DEPTH  = 4,
  parameter int CW     = 3,
  parameter int PERR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hunting,
  input logic              close_valid,
  input logic [3:0]        close_stat,
  input logic              irq,
  input logic              buf_wvalid,
  input logic [PERR_W-1:0] perr_count,
  input logic [CW-1:0]     fifo_cnt
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R4
  close_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |-> hunting);

  // R4
  close_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |-> (fifo_cnt == '0));

  // R4
  close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |=> !close_valid);

  // R5
  cd_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_valid && close_stat[2]) |-> (close_stat[3:0] == 4'b0100));

  // R7
  perr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_count >= $past(perr_count));

  // R10
  irq_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> close_valid);

  // R2
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !buf_wvalid);
endmodule

bind bsc_rx_ctrl bsc_rx_chk #(
  .DEPTH(FIFO_DEPTH), .CW(CW), .PERR_W(PERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hunting(hunting), .close_valid(close_valid),
  .close_stat(close_stat), .irq(irq), .buf_wvalid(buf_wvalid),
  .perr_count(perr_count), .fifo_cnt(fifo_cnt)
);

// File: tb/test_bsc_rx_ctrl.sv
module test_bsc_rx_ctrl;
  logic       clk, rst_n;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_par_err, rx_crc_err, rx_ctl_end;
  logic       sync_found, carrier_ok, irq_en, buf_ready;
  logic [7:0] buf_wdata;
  logic       buf_wvalid, close_valid, irq, hunting;
  logic [3:0] close_stat, perr_count;

  int n_cmp = 0, n_bad = 0, close_cnt = 0, exp_perr = 0;
  logic [3:0] last_stat;
  logic       last_irq;
  logic [7:0] got[$];

  bsc_rx_ctrl i_bsc_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_crc_err(rx_crc_err), .rx_ctl_end(rx_ctl_end),
    .sync_found(sync_found), .carrier_ok(carrier_ok), .irq_en(irq_en),
    .buf_ready(buf_ready), .buf_wdata(buf_wdata), .buf_wvalid(buf_wvalid),
    .close_valid(close_valid), .close_stat(close_stat), .irq(irq),
    .perr_count(perr_count), .hunting(hunting)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // sample 1 ns before each rising edge
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      if (buf_wvalid && buf_ready) got.push_back(buf_wdata);
      if (close_valid) begin
        close_cnt++;
        last_stat = close_stat;
        last_irq  = irq;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic par, input logic crc,
                      input logic fin);
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1; rx_par_err = par;
    rx_crc_err = crc; rx_ctl_end = fin;
    if (par && !hunting && exp_perr < 15) exp_perr++;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_crc_err = 1'b0; rx_ctl_end = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); sync_found = 1'b1;
    @(negedge clk); sync_found = 1'b0;
  endtask

  task automatic wait_close(input string req, input int start);
    for (int i = 0; i < 40 && close_cnt == start; i++) @(negedge clk);
    check({req, " close seen"}, int'(close_cnt > start), 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 hunting", hunting, 1);
    check("R1 close_valid", close_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 buf_wvalid", buf_wvalid, 0);
    check("R1 perr_count", perr_count, 0);
  endtask

  task automatic t_hunt_and_end();
    int c0;
    got.delete();
    buf_ready = 1'b1;
    send(8'h11, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R2 dropped in hunt", got.size(), 0);
    do_sync();
    check("R2 left hunt", hunting, 0);
    c0 = close_cnt;
    send(8'h22, 1'b0, 1'b0, 1'b0);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    wait_close("R9", c0);
    check("R2 count", got.size(), 2);
    if (got.size() == 2) begin
      check("R2 byte0", got[0], 8'h22);
      check("R9 end byte written", got[1], 8'h33);
    end
    check("R9 status", last_stat, 4'b0000);
    check("R10 irq enabled", last_irq, 1);
    check("R4 back to hunt", hunting, 1);
  endtask

  task automatic t_overrun();
    int c0;
    got.delete();
    buf_ready = 1'b0;
    do_sync();
    c0 = close_cnt;
    send(8'hA0, 1'b0, 1'b0, 1'b0);
    send(8'hA1, 1'b0, 1'b0, 1'b0);
    send(8'hA2, 1'b0, 1'b0, 1'b0);
    send(8'hA3, 1'b0, 1'b0, 1'b0);
    send(8'hA4, 1'b0, 1'b0, 1'b0);
    send(8'hA5, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R4 no close before drain", close_cnt, c0);
    buf_ready = 1'b1;
    wait_close("R3", c0);
    check("R3 count", got.size(), 4);
    if (got.size() == 4) begin
      check("R3 head kept", got[0], 8'hA0);
      check("R3 third kept", got[2], 8'hA2);
      check("R3 newest replaced", got[3], 8'hA4);
    end
    check("R3 status", last_stat, 4'b1000);
  endtask

  task automatic t_parity();
    int c0;
    got.delete();
    buf_ready = 1'b1;
    do_sync();
    c0 = close_cnt;
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    send(8'hA5, 1'b1, 1'b0, 1'b0);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    wait_close("R6", c0);
    check("R6 count", got.size(), 2);
    if (got.size() == 2) check("R6 bad byte written", got[1], 8'hA5);
    check("R6 status", last_stat, 4'b0010);
    check("R7 incremented", perr_count, exp_perr);
  endtask

  task automatic t_carrier();
    got.delete();
    buf_ready = 1'b0;
    do_sync();
    send(8'h40, 1'b0, 1'b0, 1'b0);
    send(8'h41, 1'b1, 1'b0, 1'b0);
    @(negedge clk); carrier_ok = 1'b0;
    @(negedge clk); #1;
    check("R5 immediate close", close_valid, 1);
    check("R5 status only CD", close_stat, 4'b0100);
    check("R5 hunting", hunting, 1);
    carrier_ok = 1'b1;
    buf_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 queue discarded", got.size(), 0);
    check("R7 counted before loss", perr_count, exp_perr);
  endtask

  task automatic t_crc(input logic c0v, input logic c1v, input int exp_cr);
    int c0;
    got.delete();
    buf_ready = 1'b1;
    do_sync();
    c0 = close_cnt;
    send(8'hC0, 1'b0, c0v, 1'b0);
    send(8'hC1, 1'b0, c1v, 1'b1);
    wait_close("R8", c0);
    check("R8 lagged CR", last_stat, exp_cr);
  endtask

  task automatic t_crc_single();
    int c0;
    do_sync();
    c0 = close_cnt;
    send(8'hD0, 1'b0, 1'b1, 1'b1);
    wait_close("R8", c0);
    check("R8 single char CR", last_stat, 4'b0000);
  endtask

  task automatic t_irq_off();
    int c0;
    irq_en = 1'b0;
    do_sync();
    c0 = close_cnt;
    send(8'hE0, 1'b0, 1'b0, 1'b1);
    wait_close("R10", c0);
    check("R10 irq masked", last_irq, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 17; k++) begin
      int c0;
      do_sync();
      c0 = close_cnt;
      send(8'h0F, 1'b1, 1'b0, 1'b0);
      wait_close("R7", c0);
    end
    check("R7 saturated", perr_count, 15);
  endtask

  initial begin
    rst_n = 1'b0; rx_byte = '0; rx_valid = 1'b0; rx_par_err = 1'b0;
    rx_crc_err = 1'b0; rx_ctl_end = 1'b0; sync_found = 1'b0;
    carrier_ok = 1'b1; irq_en = 1'b1; buf_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_hunt_and_end();
    t_overrun();
    t_parity();
    t_carrier();
    t_crc(1'b1, 1'b0, 4'b0001);
    t_crc(1'b0, 1'b1, 4'b0000);
    t_crc_single();
    t_irq_off();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule